// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block merges up to sixteen interrupt sources into one request line for a processor. Two identical eight-line controller units sit inside it. The main unit drives the processor request. The subordinate unit's request output feeds line 2 of the main unit, and software walks the cascade one unit at a time. Each unit has a byte-wide register port with one address bit. A write with bit 4 set restarts the unit and opens a short run of set-up words: vector base, then cascade word, then mode word. After that, writes to address 1 load the line mask.

Software finds the source by polling. It writes a poll command and then reads address 0. The read returns the best pending level and marks it in service. Software retires the level with a specific end-of-interrupt command. A separate trigger-select byte per unit picks edge or level sensing for each line. The block also presents a resolved vector for the winning source on `int_vec`. This vector is the unit's base plus its level, and it is taken from the subordinate unit when the winning main line carries the subordinate.

Top module: `cascade_intc`

## Requirements
- R1: After reset, and after any address-0 write with bit 4 set (a restart word), the unit's mask reads 0xFF, its in-service byte is 0x00 and every latched edge request is discarded.
- R2: After a restart word, address-1 writes are taken in this order: vector base (bits 7:3 kept), cascade word (skipped when restart bit 1 is 1), and mode word (skipped when restart bit 0 is 0). Later address-1 writes load the mask, which reads back at address 1.
- R3: A mask bit of 1 keeps its line out of the request output and out of poll results. A latched edge survives while the line is masked.
- R4: Level 0 has the highest priority and level 7 the lowest. A request is served only when no in-service bit at its own level or a higher priority is set.
- R5: An address-0 write with bits 4:3 = 01 and bit 2 = 1 arms a poll. The next address-0 read returns bit 7 = pending and bits 2:0 = level, or 0x00 when nothing is pending. An address-0 read without an armed poll returns the in-service byte.
- R6: A poll read that finds a pending level sets that level's in-service bit and clears its edge latch. At most one in-service bit is set per cycle.
- R7: An address-0 write with bits 6:5 = 11 and bits 4:3 = 00 clears the in-service bit named by bits 2:0.
- R8: Writes with `cs_trig` load the trigger byte selected by `addr` (0 = main unit, 1 = subordinate unit). A bit of 1 selects level sensing, where the request follows the input. A bit of 0 selects edge sensing, where a rising input latches a request that stays after the input falls.
- R9: Main line 2 is fed by the subordinate request ORed with `irq_src[2]`. `int_vec` is {base, level} of the winning main level. When that level is set in the main cascade word, the subordinate cascade word equals that level, and the subordinate has a request, `int_vec` comes from the subordinate instead.
- R10: `int_req` is high exactly when the main unit has a servable request. `int_vec` is 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_main | input | 1 | Selects the main unit register port |
| cs_sub | input | 1 | Selects the subordinate unit register port |
| cs_trig | input | 1 | Selects the trigger-select bytes |
| addr | input | 1 | Register address bit |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0x00 when no read is selected |
| irq_src | input | 16 | Sources: bits 7:0 go to the main unit, bits 15:8 to the subordinate |
| int_req | output | 1 | Request to the processor |
| int_vec | output | 8 | Vector of the winning source |

## Verification
A corrupt in-service byte shows in two ways. A later request is held back when it should be served, or is served when it should be held, and `int_req` shows this in the very cycle of the fault. The in-service byte can also be read back on the next non-poll read of address 0. A stale or missing edge latch changes the request output within one clock of the rising input. A wrong position in the set-up sequence shows as a mask read-back that differs from the last write. A broken cascade match shows on `int_vec` as soon as the subordinate requests.

// File: rtl/intc_pkg.sv
// Shared constants and types for the cascadable interrupt controller.
// Assumes eight lines per unit and a byte-wide register port.
package intc_pkg;
    localparam int DATA_W = 8;
    localparam int LINES  = 8;
    localparam int LVL_W  = $clog2(LINES);
    localparam int BASE_W = DATA_W - LVL_W;

    // Set-up sequence position of one unit
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } setup_e;
endpackage

// File: rtl/intc_cmd.sv
// Register-port decoder of one unit: holds the set-up sequence, mask,
// vector base, cascade word and poll arming, and issues one-cycle pulses
// for restart, poll take and end-of-interrupt.
// Assumes at most one of read/write acts per unit per cycle in normal use.
module intc_cmd
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_o,
    output logic [BASE_W-1:0] base_o,
    output logic [DATA_W-1:0] casc_o,
    output logic              poll_arm_o,
    output logic              restart_o,
    output logic              take_o,
    output logic              eoi_o,
    output logic [LVL_W-1:0]  eoi_lvl_o
);
    setup_e      state_q;
    logic        single_q;
    logic        need_mode_q;
    logic        wr0, wr1;

    // Decode strobes of this cycle
    always_comb begin
        wr0       = sel && wr_en && !addr;
        wr1       = sel && wr_en && addr;
        restart_o = wr0 && wdata[4];
        eoi_o     = wr0 && !wdata[4] && !wdata[3] && (wdata[6:5] == 2'b11);
        eoi_lvl_o = wdata[LVL_W-1:0];
        take_o    = sel && rd_en && !addr && poll_arm_o;
    end

    // Set-up sequence and register loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            single_q    <= 1'b0;
            need_mode_q <= 1'b0;
            mask_o      <= '1;
            base_o      <= '0;
            casc_o      <= '0;
        end else if (restart_o) begin
            state_q     <= ST_BASE;
            single_q    <= wdata[1];
            need_mode_q <= wdata[0];
            mask_o      <= '1;
        end else if (wr1) begin
            unique case (state_q)
                ST_BASE: begin
                    base_o <= wdata[DATA_W-1:LVL_W];
                    if (!single_q)        state_q <= ST_CASC;
                    else if (need_mode_q) state_q <= ST_MODE;
                    else                  state_q <= ST_RUN;
                end
                ST_CASC: begin
                    casc_o  <= wdata;
                    state_q <= need_mode_q ? ST_MODE : ST_RUN;
                end
                ST_MODE: state_q <= ST_RUN;
                default: mask_o  <= wdata;
            endcase
        end
    end

    // Poll arming: set by poll command, dropped by the read or a restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_arm_o <= 1'b0;
        end else if (restart_o) begin
            poll_arm_o <= 1'b0;
        end else if (wr0 && wdata[3]) begin
            poll_arm_o <= wdata[2];
        end else if (take_o) begin
            poll_arm_o <= 1'b0;
        end
    end
endmodule

// File: rtl/intc_resolve.sv
// Request and in-service logic of one unit: per-line edge latches,
// edge/level request selection, masking, fixed priority resolution with
// in-service blocking, and the in-service register.
// Assumes take/eoi/restart are single-cycle pulses from the decoder.
module intc_resolve
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines,
    input  logic [LINES-1:0] trig,
    input  logic [LINES-1:0] mask,
    input  logic             restart,
    input  logic             take,
    input  logic             eoi,
    input  logic [LVL_W-1:0] eoi_lvl,
    output logic [LINES-1:0] isr_o,
    output logic             valid_o,
    output logic [LVL_W-1:0] lvl_o
);
    logic [LINES-1:0] line_q;
    logic [LINES-1:0] latch_q;
    logic [LINES-1:0] req;
    logic [LINES-1:0] elig;
    logic             found;
    logic [LVL_W-1:0] best;
    logic             isr_any;
    logic [LVL_W-1:0] isr_first;

    // Per-line input history and edge latch
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic acked;
        assign acked = take && valid_o && (lvl_o == LVL_W'(g));

        // Remembers last sampled input level
        always_ff @(posedge clk) begin
            if (!rst_n) line_q[g] <= 1'b0;
            else        line_q[g] <= lines[g];
        end

        // Latches a rising edge in edge mode until acknowledged or restarted
        always_ff @(posedge clk) begin
            if (!rst_n || restart) begin
                latch_q[g] <= 1'b0;
            end else if (trig[g]) begin
                latch_q[g] <= 1'b0;
            end else if (lines[g] && !line_q[g]) begin
                latch_q[g] <= 1'b1;
            end else if (acked) begin
                latch_q[g] <= 1'b0;
            end
        end

        assign req[g] = trig[g] ? lines[g] : latch_q[g];
    end

    // Fixed-priority search over eligible requests and in-service bits
    always_comb begin
        elig      = req & ~mask;
        found     = 1'b0;
        best      = '0;
        isr_any   = 1'b0;
        isr_first = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                best  = LVL_W'(i);
            end
            if (isr_o[i]) begin
                isr_any   = 1'b1;
                isr_first = LVL_W'(i);
            end
        end
        valid_o = found && (!isr_any || (best < isr_first));
        lvl_o   = valid_o ? best : '0;
    end

    // In-service register: set by poll take, cleared by specific EOI
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            isr_o <= '0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (take && valid_o && (lvl_o == LVL_W'(i))) begin
                    isr_o[i] <= 1'b1;
                end else if (eoi && (eoi_lvl == LVL_W'(i))) begin
                    isr_o[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/intc_unit.sv
// One eight-line controller unit: register decoder, resolver and read mux.
// Assumes trigger-select bits are held outside the unit.
module intc_unit
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LINES-1:0]  lines,
    input  logic [LINES-1:0]  trig,
    output logic [DATA_W-1:0] rd_byte,
    output logic              int_o,
    output logic [LVL_W-1:0]  lvl_o,
    output logic [LINES-1:0]  isr_o,
    output logic              poll_arm_o,
    output logic [BASE_W-1:0] base_o,
    output logic [DATA_W-1:0] casc_o
);
    logic [DATA_W-1:0] mask;
    logic              restart, take, eoi;
    logic [LVL_W-1:0]  eoi_lvl;

    intc_cmd u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .addr       (addr),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wdata      (wdata),
        .mask_o     (mask),
        .base_o     (base_o),
        .casc_o     (casc_o),
        .poll_arm_o (poll_arm_o),
        .restart_o  (restart),
        .take_o     (take),
        .eoi_o      (eoi),
        .eoi_lvl_o  (eoi_lvl)
    );

    intc_resolve u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines   (lines),
        .trig    (trig),
        .mask    (mask),
        .restart (restart),
        .take    (take),
        .eoi     (eoi),
        .eoi_lvl (eoi_lvl),
        .isr_o   (isr_o),
        .valid_o (int_o),
        .lvl_o   (lvl_o)
    );

    // Read data: mask at address 1, poll result or in-service byte at 0
    always_comb begin
        if (addr)            rd_byte = mask;
        else if (poll_arm_o) rd_byte = {int_o, {(DATA_W-1-LVL_W){1'b0}}, lvl_o};
        else                 rd_byte = isr_o;
    end
endmodule

// File: rtl/cascade_intc.sv
// Top level: a main and a subordinate unit in cascade, the two
// trigger-select bytes, read-data selection and vector resolution.
// Assumes only one chip select is active per access.
module cascade_intc
    import intc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_main,
    input  logic                cs_sub,
    input  logic                cs_trig,
    input  logic                addr,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [2*LINES-1:0]  irq_src,
    output logic                int_req,
    output logic [DATA_W-1:0]   int_vec
);
    localparam int UNITS = 2;
    localparam int CASC_LINE = 2;

    logic [UNITS-1:0][LINES-1:0] trig_q;
    logic [LINES-1:0]  m_lines;
    logic [DATA_W-1:0] m_rd, s_rd;
    logic              m_int, s_int;
    logic [LVL_W-1:0]  m_lvl, s_lvl;
    logic [LINES-1:0]  m_isr, s_isr;
    logic              m_poll, s_poll;
    logic [BASE_W-1:0] m_base, s_base;
    logic [DATA_W-1:0] m_casc, s_casc;
    logic              casc_hit;

    // Trigger-select bytes, one per unit, chosen by addr
    for (genvar u = 0; u < UNITS; u++) begin : g_trig
        always_ff @(posedge clk) begin
            if (!rst_n)                                        trig_q[u] <= '0;
            else if (cs_trig && wr_en && (addr == u[0]))       trig_q[u] <= wdata;
        end
    end

    assign m_lines = {irq_src[LINES-1:CASC_LINE+1],
                      irq_src[CASC_LINE] | s_int,
                      irq_src[CASC_LINE-1:0]};

    intc_unit u_main (
        .clk(clk), .rst_n(rst_n), .sel(cs_main), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .lines(m_lines), .trig(trig_q[0]),
        .rd_byte(m_rd), .int_o(m_int), .lvl_o(m_lvl), .isr_o(m_isr),
        .poll_arm_o(m_poll), .base_o(m_base), .casc_o(m_casc)
    );

    intc_unit u_sub (
        .clk(clk), .rst_n(rst_n), .sel(cs_sub), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .lines(irq_src[2*LINES-1:LINES]), .trig(trig_q[1]),
        .rd_byte(s_rd), .int_o(s_int), .lvl_o(s_lvl), .isr_o(s_isr),
        .poll_arm_o(s_poll), .base_o(s_base), .casc_o(s_casc)
    );

    // Read data selection by chip select
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (cs_main)      rdata = m_rd;
            else if (cs_sub)  rdata = s_rd;
            else if (cs_trig) rdata = trig_q[addr];
        end
    end

    // Vector resolution through the cascade
    always_comb begin
        casc_hit = m_int && m_casc[m_lvl] && s_int &&
                   (s_casc == DATA_W'(m_lvl));
        int_req  = m_int;
        if (!m_int)       int_vec = '0;
        else if (casc_hit) int_vec = {s_base, s_lvl};
        else              int_vec = {m_base, m_lvl};
    end
endmodule

// File: rtl/intc_chk.sv
// Assertion checker bound to the top level; watches the port strobes
// and the per-unit in-service and request signals.
module intc_chk
    import intc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_main,
    input logic              addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              m_int,
    input logic              s_int,
    input logic [LINES-1:0]  m_isr,
    input logic [LINES-1:0]  s_isr,
    input logic              m_poll
);
    assert_restart_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_main && wr_en && !addr && wdata[4]) |=> ((m_isr == '0) && !m_int));

    assert_top_blocks_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_isr[0] |-> !m_int);

    assert_top_blocks_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_isr[0] |-> !s_int);

    assert_poll_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_main && rd_en && !wr_en && !addr && m_poll && rdata[7])
        |=> m_isr[$past(rdata[LVL_W-1:0])]);

    assert_one_new_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(m_isr & ~$past(m_isr)) <= 1);

    assert_eoi_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_main && wr_en && !rd_en && !addr && !wdata[4] && !wdata[3] &&
         (wdata[6:5] == 2'b11)) |=> !m_isr[$past(wdata[LVL_W-1:0])]);
endmodule

bind cascade_intc intc_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_main (cs_main),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .m_int   (m_int),
    .s_int   (s_int),
    .m_isr   (m_isr),
    .s_isr   (s_isr),
    .m_poll  (m_poll)
);

// File: tb/test_cascade_intc.sv
module test_cascade_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_main = 0, cs_sub = 0, cs_trig = 0;
    logic        addr = 0, wr_en = 0, rd_en = 0;
    logic [7:0]  wdata = 0;
    logic [7:0]  rdata;
    logic [15:0] irq_src = 0;
    logic        int_req;
    logic [7:0]  int_vec;
    int          checks = 0;
    int          errors = 0;

    localparam int MAIN = 0, SUB = 1, TRIG = 2;

    always #10 clk = ~clk;

    cascade_intc i_cascade_intc (
        .clk(clk), .rst_n(rst_n), .cs_main(cs_main), .cs_sub(cs_sub),
        .cs_trig(cs_trig), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq_src(irq_src),
        .int_req(int_req), .int_vec(int_vec)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic pick(input int unit);
        cs_main = (unit == MAIN);
        cs_sub  = (unit == SUB);
        cs_trig = (unit == TRIG);
    endtask

    task automatic wr(input int unit, input logic a, input logic [7:0] d);
        @(negedge clk);
        pick(unit); addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        pick(-1); wr_en = 0;
    endtask

    task automatic rd(input int unit, input logic a, output logic [7:0] d);
        @(negedge clk);
        pick(unit); addr = a; rd_en = 1;
        #5 d = rdata;
        @(negedge clk);
        pick(-1); rd_en = 0;
    endtask

    task automatic pulse(input int line);
        @(negedge clk); irq_src[line] = 1'b1;
        @(negedge clk); irq_src[line] = 1'b0;
        @(negedge clk);
    endtask

    task automatic outs(input string req, input logic r, input logic [7:0] v);
        #1;
        check(req, {7'd0, int_req}, {7'd0, r});
        check(req, int_vec, v);
    endtask

    task automatic setup_both();
        wr(MAIN, 0, 8'h11); wr(MAIN, 1, 8'h00); wr(MAIN, 1, 8'h04); wr(MAIN, 1, 8'h01);
        wr(SUB, 0, 8'h11);  wr(SUB, 1, 8'h08);  wr(SUB, 1, 8'h02);  wr(SUB, 1, 8'h01);
        wr(TRIG, 0, 8'h04); wr(TRIG, 1, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(MAIN, 1, d); check("R1 reset mask", d, 8'hFF);
        rd(MAIN, 0, d); check("R1 reset isr", d, 8'h00);
        outs("R10 idle", 0, 8'h00);
        setup_both();
        rd(MAIN, 1, d); check("R2 mask after full setup", d, 8'hFF);
        rd(TRIG, 0, d); check("R8 trig readback", d, 8'h04);
    endtask

    task automatic t_edge();
        logic [7:0] d;
        wr(MAIN, 1, 8'hDF);
        pulse(5);
        outs("R8 edge latched", 1, 8'h05);
        wr(MAIN, 0, 8'h0C);
        rd(MAIN, 0, d); check("R5 poll edge line", d, 8'h85);
        outs("R6 taken line blocked", 0, 8'h00);
        rd(MAIN, 0, d); check("R5 isr read", d, 8'h20);
        wr(MAIN, 0, 8'h65);
        rd(MAIN, 0, d); check("R7 eoi clears", d, 8'h00);
        outs("R6 latch cleared by poll", 0, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        pulse(3);
        outs("R3 masked line", 0, 8'h00);
        wr(MAIN, 0, 8'h0C);
        rd(MAIN, 0, d); check("R3 poll ignores masked", d, 8'h00);
        wr(MAIN, 1, 8'hD7);
        outs("R3 latch kept while masked", 1, 8'h03);
        wr(MAIN, 0, 8'h0C);
        rd(MAIN, 0, d); check("R5 poll line3", d, 8'h83);
        wr(MAIN, 0, 8'h63);
        outs("R7 after eoi", 0, 8'h00);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        wr(TRIG, 0, 8'h1C);
        wr(MAIN, 1, 8'hE7);
        @(negedge clk); irq_src[4] = 1; irq_src[3] = 1;
        outs("R4 lower index wins", 1, 8'h03);
        wr(MAIN, 0, 8'h0C);
        rd(MAIN, 0, d); check("R4 poll best", d, 8'h83);
        outs("R4 blocked by isr", 0, 8'h00);
        @(negedge clk); irq_src[3] = 0;
        wr(MAIN, 0, 8'h63);
        outs("R4 next after eoi", 1, 8'h04);
        wr(MAIN, 0, 8'h0C);
        rd(MAIN, 0, d); check("R4 poll line4", d, 8'h84);
        @(negedge clk); irq_src[3] = 1;
        outs("R4 higher nests", 1, 8'h03);
        wr(MAIN, 0, 8'h0C);
        rd(MAIN, 0, d); check("R4 nested poll", d, 8'h83);
        rd(MAIN, 0, d); check("R4 nested isr", d, 8'h18);
        @(negedge clk); irq_src[3] = 0; irq_src[4] = 0;
        wr(MAIN, 0, 8'h63); wr(MAIN, 0, 8'h64);
        rd(MAIN, 0, d); check("R7 both retired", d, 8'h00);
        @(negedge clk); irq_src[4] = 1;
        outs("R8 level high", 1, 8'h04);
        @(negedge clk); irq_src[4] = 0;
        outs("R8 level follows", 0, 8'h00);
        wr(TRIG, 0, 8'h04);
    endtask

    task automatic t_cascade();
        logic [7:0] d;
        wr(MAIN, 1, 8'hFB);
        wr(SUB, 1, 8'hF7);
        pulse(11);
        outs("R9 vector from sub", 1, 8'h0B);
        wr(MAIN, 0, 8'h0C);
        rd(MAIN, 0, d); check("R9 main poll line2", d, 8'h82);
        outs("R9 main blocked", 0, 8'h00);
        wr(SUB, 0, 8'h0C);
        rd(SUB, 0, d); check("R9 sub poll", d, 8'h83);
        wr(SUB, 0, 8'h63);
        wr(MAIN, 0, 8'h62);
        rd(SUB, 0, d); check("R7 sub isr clear", d, 8'h00);
        rd(MAIN, 0, d); check("R7 main isr clear", d, 8'h00);
        outs("R10 idle after cascade", 0, 8'h00);
    endtask

    task automatic t_restart();
        logic [7:0] d;
        wr(MAIN, 1, 8'hDF);
        pulse(5);
        wr(MAIN, 0, 8'h0C);
        rd(MAIN, 0, d); check("R6 poll before restart", d, 8'h85);
        pulse(0);
        wr(MAIN, 0, 8'h12);
        rd(MAIN, 0, d); check("R1 restart clears isr", d, 8'h00);
        rd(MAIN, 1, d); check("R1 restart masks", d, 8'hFF);
        wr(MAIN, 1, 8'h20);
        wr(MAIN, 1, 8'hFE);
        rd(MAIN, 1, d); check("R2 short sequence", d, 8'hFE);
        outs("R1 latch discarded", 0, 8'h00);
        pulse(0);
        outs("R2 new base", 1, 8'h20);
        wr(MAIN, 0, 8'h0C);
        rd(MAIN, 0, d); check("R5 poll line0", d, 8'h80);
        wr(MAIN, 0, 8'h60);
        wr(MAIN, 0, 8'h11); wr(MAIN, 1, 8'h00); wr(MAIN, 1, 8'h04); wr(MAIN, 1, 8'h01);
        wr(MAIN, 1, 8'hAA);
        rd(MAIN, 1, d); check("R2 full sequence then mask", d, 8'hAA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_edge();
        t_mask();
        t_priority();
        t_cascade();
        t_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule